// File: doc/BRIEF.md
# Tile Layer Priority Compositor

This block merges up to four tile layer pixels into two output planes: one meant to sit underneath a separately rendered 3D image and one meant to sit over it. Each layer arrives as a 16-bit palette colour holding a transparency flag and three 5-bit channels. A per-layer enable and a per-layer "above 3D" flag decide whether a layer takes part and which plane it goes to. Before the layers are merged, every colour gets a signed RGB offset. The offset is shared by a pair of neighbouring layers. It is scaled down to the 5-bit channel range and saturated.

Within a plane the layers stack from the highest index (back) to the lowest index (front). A transparent colour lets the layer behind it show through. The back-most enabled layer of a plane is always drawn, even when its colour is transparent. Each plane produces an RGB pixel and a coverage flag. The combination with the 3D image happens outside this block. The datapath is a two-stage pipeline that accepts one pixel per clock.

Top module: `tlc_compositor`

## Requirements
- R1: A palette colour is 16 bits: bit 15 is the transparency flag, bits 14:10 blue, bits 9:5 green, bits 4:0 red. Layer i occupies bits 16*i+15 : 16*i of `pix_in`. Output pixels are packed as {red[14:10], green[9:5], blue[4:0]}.
- R2: A layer whose `layer_en` bit is 0 has no effect on either plane.
- R3: `above_3d[i]`=1 places layer i in the top plane; 0 places it in the bottom plane.
- R4: Within a plane, the lowest-index enabled layer with an opaque colour (flag 0) is shown.
- R5: When every enabled layer of a plane is transparent, the colour of that plane's highest-index enabled layer is shown, and its transparency flag is ignored.
- R6: A plane with no enabled layer outputs coverage 0 and black. Otherwise coverage is 1.
- R7: Layers 2p and 2p+1 use offset pair p of `pair_ofs` (bits 24p+23:24p): red at 23:16, green at 15:8, blue at 7:0, each a signed 8-bit value. Each offset is shifted arithmetically right by 3, added to its channel, and the sum is clamped to 0..31.
- R8: Results appear on the outputs two clock edges after the inputs are sampled, and `out_valid` follows `in_valid` with the same delay. A synchronous reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel set is valid |
| pix_in | input | 64 | Four palette colours, layer i at 16*i |
| layer_en | input | 4 | Per-layer enable |
| above_3d | input | 4 | Per-layer plane select, 1 = top |
| pair_ofs | input | 48 | Two signed RGB offset words, 24 bits per layer pair |
| out_valid | output | 1 | Output pixels valid |
| bot_rgb | output | 15 | Bottom plane pixel {r,g,b} |
| bot_cov | output | 1 | Bottom plane coverage |
| top_rgb | output | 15 | Top plane pixel {r,g,b} |
| top_cov | output | 1 | Top plane coverage |

## Verification
Two functions can act on the same layer in one cycle: the offset saturation and the transparency fallback. A transparent back-most layer can be chosen as the visible colour while its channels are also being clamped at 0 or 31. The bench drives directed cases with all-transparent planes and offsets of +127 and -128 on channels of 31 and 0. It then mixes these cases with random colours, enables, plane splits and offsets. Each plane's colour and coverage are compared with a bench model that picks the layer first and then applies the clamped offset.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int CH_W      = 5;
  localparam int OFS_W     = 8;
  localparam int SHIFT     = OFS_W - CH_W;
  localparam int PAL_W     = 16;
  localparam int RGB_W     = 3 * CH_W;
  localparam int OFS_REG_W = 3 * OFS_W;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;

  // palette word: {t, b, g, r}
  function automatic rgb_t pal_to_rgb(input logic [PAL_W-1:0] p);
    rgb_t c;
    c.r = p[CH_W-1:0];
    c.g = p[2*CH_W-1:CH_W];
    c.b = p[3*CH_W-1:2*CH_W];
    return c;
  endfunction
endpackage

// File: rtl/tlc_offset_adj.sv
module tlc_offset_adj
  import tlc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  rgb_t                 col,
  input  logic [OFS_REG_W-1:0] ofs,
  output rgb_t                 q
);
  localparam int SW = OFS_W + 1;

  function automatic logic [CH_W-1:0] adj(input logic [CH_W-1:0] c,
                                          input logic [OFS_W-1:0] o);
    logic signed [OFS_W-1:0] osh;
    logic signed [SW-1:0]    sum;
    osh = $signed(o) >>> SHIFT;
    sum = $signed({{(SW-CH_W){1'b0}}, c}) + $signed({{(SW-OFS_W){osh[OFS_W-1]}}, osh});
    if (sum[SW-1])                  return '0;
    else if (sum[SW-2:CH_W] != '0)  return '1;
    else                            return sum[CH_W-1:0];
  endfunction

  rgb_t nxt;
  always_comb begin
    nxt.r = adj(col.r, ofs[3*OFS_W-1:2*OFS_W]);
    nxt.g = adj(col.g, ofs[2*OFS_W-1:OFS_W]);
    nxt.b = adj(col.b, ofs[OFS_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  // R7: a zero offset leaves the colour untouched
  a_r7_zero_passthru: assert property (@(posedge clk) disable iff (rst)
    (ofs == '0) |=> (q == $past(col)));
endmodule

// File: rtl/tlc_plane_select.sv
module tlc_plane_select
  import tlc_pkg::*;
#(
  parameter int NUM_LAYERS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  rgb_t                  col [NUM_LAYERS],
  input  logic [NUM_LAYERS-1:0] transp,
  input  logic [NUM_LAYERS-1:0] member,
  output rgb_t                  rgb,
  output logic                  cov
);
  localparam int SEL_W = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1;

  logic [SEL_W-1:0] sel;
  logic             found;

  // walk back to front: the first member always lands, later opaque ones cover it
  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = NUM_LAYERS - 1; i >= 0; i--) begin
      if (member[i] && (!transp[i] || !found)) begin
        sel   = SEL_W'(i);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rgb <= '0;
      cov <= 1'b0;
    end else begin
      rgb <= found ? col[sel] : '0;
      cov <= found;
    end
  end

  a_r6_empty_black: assert property (@(posedge clk) disable iff (rst)
    (member == '0) |=> (!cov && rgb == '0));
  a_r4_member_covers: assert property (@(posedge clk) disable iff (rst)
    (member != '0) |=> cov);
endmodule

// File: rtl/tlc_compositor.sv
module tlc_compositor
  import tlc_pkg::*;
#(
  parameter int NUM_LAYERS = 4,
  localparam int NUM_PAIRS = (NUM_LAYERS + 1) / 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            in_valid,
  input  logic [NUM_LAYERS*PAL_W-1:0]     pix_in,
  input  logic [NUM_LAYERS-1:0]           layer_en,
  input  logic [NUM_LAYERS-1:0]           above_3d,
  input  logic [NUM_PAIRS*OFS_REG_W-1:0]  pair_ofs,
  output logic                            out_valid,
  output logic [RGB_W-1:0]                bot_rgb,
  output logic                            bot_cov,
  output logic [RGB_W-1:0]                top_rgb,
  output logic                            top_cov
);
  rgb_t                  s1_col [NUM_LAYERS];
  logic [NUM_LAYERS-1:0] s1_transp, s1_top, s1_bot;
  logic                  s1_valid;

  for (genvar i = 0; i < NUM_LAYERS; i++) begin : g_layer
    tlc_offset_adj u_adj (
      .clk (clk),
      .rst (rst),
      .col (pal_to_rgb(pix_in[i*PAL_W +: PAL_W])),
      .ofs (pair_ofs[(i/2)*OFS_REG_W +: OFS_REG_W]),
      .q   (s1_col[i])
    );
    always_ff @(posedge clk) begin
      if (rst) s1_transp[i] <= 1'b0;
      else     s1_transp[i] <= pix_in[i*PAL_W + PAL_W - 1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_top    <= '0;
      s1_bot    <= '0;
      s1_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      s1_top    <= layer_en & above_3d;
      s1_bot    <= layer_en & ~above_3d;
      s1_valid  <= in_valid;
      out_valid <= s1_valid;
    end
  end

  rgb_t bot_q, top_q;

  tlc_plane_select #(.NUM_LAYERS(NUM_LAYERS)) u_bot (
    .clk(clk), .rst(rst), .col(s1_col), .transp(s1_transp),
    .member(s1_bot), .rgb(bot_q), .cov(bot_cov)
  );
  tlc_plane_select #(.NUM_LAYERS(NUM_LAYERS)) u_top (
    .clk(clk), .rst(rst), .col(s1_col), .transp(s1_transp),
    .member(s1_top), .rgb(top_q), .cov(top_cov)
  );

  assign bot_rgb = bot_q;
  assign top_rgb = top_q;

  a_r8_valid_s1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_valid);
  a_r8_valid_out: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> out_valid);
  // R3: a layer sits in at most one plane
  a_r3_planes_disjoint: assert property (@(posedge clk) disable iff (rst)
    ((s1_top & s1_bot) == '0));
endmodule

// File: tb/tlc_compositor_test.sv
module tlc_compositor_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] pix_in = '0;
  logic [3:0]  layer_en = '0;
  logic [3:0]  above_3d = '0;
  logic [47:0] pair_ofs = '0;
  logic        out_valid, bot_cov, top_cov;
  logic [14:0] bot_rgb, top_rgb;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tlc_compositor uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pix_in(pix_in),
    .layer_en(layer_en), .above_3d(above_3d), .pair_ofs(pair_ofs),
    .out_valid(out_valid), .bot_rgb(bot_rgb), .bot_cov(bot_cov),
    .top_rgb(top_rgb), .top_cov(top_cov)
  );

  logic [15:0] pal [4];
  logic [23:0] ofs [2];

  function automatic int clampc(input int c, input logic [7:0] o);
    int v;
    v = c + (int'($signed(o)) >>> 3);
    if (v < 0) v = 0;
    if (v > 31) v = 31;
    return v;
  endfunction

  // returns {cov, r, g, b}
  function automatic logic [15:0] ref_plane(input logic want_top);
    int sel;
    logic [23:0] o;
    int r, g, b;
    sel = -1;
    for (int i = 3; i >= 0; i--) begin
      if (layer_en[i] && (above_3d[i] == want_top) && (!pal[i][15] || sel < 0))
        sel = i;
    end
    if (sel < 0) return 16'h0;
    o = ofs[sel/2];
    r = clampc(int'(pal[sel][4:0]),   o[23:16]);
    g = clampc(int'(pal[sel][9:5]),   o[15:8]);
    b = clampc(int'(pal[sel][14:10]), o[7:0]);
    return {1'b1, r[4:0], g[4:0], b[4:0]};
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input string tag);
    logic [15:0] eb, et;
    @(negedge clk);
    pix_in   = {pal[3], pal[2], pal[1], pal[0]};
    pair_ofs = {ofs[1], ofs[0]};
    in_valid = 1'b1;
    eb = ref_plane(1'b0);
    et = ref_plane(1'b1);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check({tag, " bottom"}, {bot_cov, bot_rgb}, eb);
    check({tag, " top"},    {top_cov, top_rgb}, et);
    check({tag, " valid R8"}, {15'h0, out_valid}, 16'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R8: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) pal[i] = '0;
    ofs[0] = '0; ofs[1] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset bottom", {bot_cov, bot_rgb}, 16'h0);
    check("R8 reset top",    {top_cov, top_rgb}, 16'h0);
    check("R8 reset valid",  {15'h0, out_valid}, 16'h0);
    rst = 1'b0;

    // R2/R6: nothing enabled
    pal[0] = 16'h1234; pal[1] = 16'h4321; pal[2] = 16'h7fff; pal[3] = 16'h0421;
    layer_en = 4'b0000; above_3d = 4'b0101;
    apply("R2 R6 none enabled");

    // R1: channel unpacking, single opaque layer 0 in bottom plane
    pal[0] = {1'b0, 5'd3, 5'd17, 5'd29};
    layer_en = 4'b0001; above_3d = 4'b0000;
    apply("R1 channel order");

    // R3: split across planes
    layer_en = 4'b1111; above_3d = 4'b1010;
    pal[0] = 16'h0011; pal[1] = 16'h0022; pal[2] = 16'h0033; pal[3] = 16'h0044;
    apply("R3 plane split");

    // R4: front transparent, next opaque wins
    above_3d = 4'b0000;
    pal[0] = 16'h8005; pal[1] = 16'h8006; pal[2] = 16'h0007; pal[3] = 16'h0008;
    apply("R4 lowest opaque");

    // R5: all transparent, back-most shown
    pal[0] = 16'h8001; pal[1] = 16'h8002; pal[2] = 16'h8003; pal[3] = 16'h8fff;
    apply("R5 all transparent");
    layer_en = 4'b0011;
    apply("R5 back-most of subset");

    // R2: disabled opaque front layer ignored
    pal[0] = 16'h0155; pal[1] = 16'h0aaa; layer_en = 4'b0010;
    apply("R2 disabled front");

    // R7: saturation high and low, pair mapping
    layer_en = 4'b0101; above_3d = 4'b0100;
    pal[0] = {1'b0, 5'd31, 5'd0, 5'd31};
    pal[2] = {1'b0, 5'd0, 5'd31, 5'd2};
    ofs[0] = {8'd127, 8'h80, 8'd127};
    ofs[1] = {8'h80, 8'd127, 8'hF8};
    apply("R7 saturate");
    ofs[0] = {8'd16, 8'hF0, 8'd7};
    ofs[1] = {8'hF9, 8'd8, 8'h00};
    apply("R7 scaled offset");

    // random mix
    for (int k = 0; k < 80; k++) begin
      for (int i = 0; i < 4; i++) pal[i] = 16'($urandom);
      layer_en = 4'($urandom);
      above_3d = 4'($urandom);
      ofs[0] = 24'($urandom);
      ofs[1] = 24'($urandom);
      apply("R3 R4 R5 R7 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule